// File: doc/BRIEF.md
# Run-time programmable maximal-length code generator

The block produces a serial pseudo-random code bit from a linear feedback shift register whose feedback polynomial and length are loaded at run time. Any order N from 1 to 16 is accepted. A single load strobe captures the coefficient string, the order and a start state. After that, every cycle with the enable high moves the register one state forward, and the code bit is read from the most significant active stage.

A period monitor sits next to the register. It counts enabled steps from the load until the register comes back to its start state. It then reports the step count once, and it raises a flag when that count equals 2^N-1, the longest possible cycle for that order. A polynomial that never brings the register back, such as one with no constant term, stops the count after 2^16 steps and raises an overrun flag. Tap selections can therefore be screened on the chip without any software model.

Top module: `pn_sequencer`

## Requirements
- R1: A cycle with `load` high captures `poly`, `order` and `seed`. From the next cycle the register holds the start state, and `code_bit` equals stage N-1 of that state (stage 0 is the newest bit).
- R2: On each step the register shifts toward the higher stages. Stage 0 takes the XOR of every stage j (j < N) for which `poly` bit N-1-j is 1. `poly` bit i is the coefficient of x^i, and bit N is the leading 1. For `poly`=10011, N=4 and start 0001, the code bits on steps 1 to 15 are 0,0,1,0,0,1,1,0,1,0,1,1,1,1,0.
- R3: While `en` is low and `load` is low, the register state, `code_bit` and the period count do not change.
- R4: Seed bits at or above position N are ignored. If the remaining low N seed bits are all zero, the start state becomes 1.
- R5: An `order` value of 0 is treated as 1, and a value above 16 is treated as 16.
- R6: `period_valid` is high for exactly one cycle. That cycle follows the first step after a load that brings the state back to the start state, and `period` then holds the number of steps taken. It keeps that value until the next load.
- R7: `maximal` is high, from the `period_valid` cycle until the next load, exactly when `period` equals 2^N-1.
- R8: Polynomials with a shorter cycle report it exactly: 11111 gives 5, 1001001 gives 9, 1010111 gives 21 and 100011011 gives 51, each with `maximal` low.
- R9: If the state has not returned after 2^16 steps, `overrun` goes high from the cycle after step 65536. `period` stays 0 and `period_valid` never pulses.
- R10: After reset `code_bit` is 1, and `period`, `period_valid`, `maximal` and `overrun` are 0.
- R11: `load` takes priority over `en` in the same cycle. It restarts the monitor, which clears `period`, `maximal` and `overrun`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Advance one state this cycle |
| load | input | 1 | Capture polynomial, order and seed |
| poly | input | 17 | Coefficient string, bit i is x^i |
| order | input | 5 | Register length N |
| seed | input | 16 | Start state |
| code_bit | output | 1 | Serial code, top active stage |
| period | output | 17 | Measured cycle length in steps |
| period_valid | output | 1 | One-cycle pulse when the cycle closes |
| maximal | output | 1 | Period equals 2^N-1 |
| overrun | output | 1 | No return within 2^16 steps |

## Verification
The bench walks a table of polynomials of orders 1 to 16 that mixes full-length and short cycles, and compares the reported period with known cycle lengths. A monitor that counted from the wrong step, or compared against the current state instead of the next one, would be off by one on every entry. A tap map reversed against the coefficient order would break the 15-step code-bit pattern. The bench also sends a zero seed, seed bits above the order, and orders 0 and 20. Without the seed fix-up the register would lock at zero and report an overrun, and without the order clamp the chain length would be wrong, which moves the first 1 at the output. A polynomial with no constant term is run for 2^16 steps to check that the overrun flag rises on exactly the right step and that no false period is reported before it.

// File: rtl/pn_pkg.sv
package pn_pkg;
    localparam int PN_W_DEFAULT = 16;

    typedef enum logic [1:0] {
        MON_IDLE,
        MON_RUN,
        MON_DONE,
        MON_OVER
    } mon_phase_e;
endpackage

// File: rtl/pn_shift_core.sv
module pn_shift_core #(
    parameter int W  = 16,
    parameter int OW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load,
    input  logic [W:0]    poly_in,
    input  logic [OW-1:0] order_in,
    input  logic [W-1:0]  seed_in,
    output logic [W-1:0]  seed_eff,
    output logic [W-1:0]  state_nxt,
    output logic [W-1:0]  mask_o,
    output logic          step,
    output logic          code_bit
);
    typedef struct packed {
        logic [W:0]    poly;
        logic [OW-1:0] ord;
        logic [W-1:0]  mask;
        logic [W-1:0]  st;
    } core_t;

    core_t core_d, core_q;
    logic [OW-1:0] ld_ord;
    logic [W-1:0]  ld_mask;
    logic          fb;
    logic [OW-1:0] ix;

    function automatic logic [OW-1:0] clamp_ord(input logic [OW-1:0] o);
        if (o == '0)
            return OW'(1);
        else if (int'(o) > W)
            return OW'(W);
        else
            return o;
    endfunction

    function automatic logic [W-1:0] mask_of(input logic [OW-1:0] n);
        logic [W-1:0] m;
        for (int i = 0; i < W; i++)
            m[i] = (OW'(i) < n);
        return m;
    endfunction

    always_comb begin
        ld_ord   = clamp_ord(order_in);
        ld_mask  = mask_of(ld_ord);
        seed_eff = seed_in & ld_mask;
        if (seed_eff == '0)
            seed_eff = W'(1);

        fb = 1'b0;
        ix = '0;
        for (int j = 0; j < W; j++) begin
            ix = core_q.ord - OW'(1) - OW'(j);
            if (OW'(j) < core_q.ord)
                fb = fb ^ (core_q.st[j] & core_q.poly[ix]);
        end
        state_nxt = {core_q.st[W-2:0], fb} & core_q.mask;
        step      = en & ~load;

        core_d = core_q;
        if (load) begin
            core_d.poly = poly_in;
            core_d.ord  = ld_ord;
            core_d.mask = ld_mask;
            core_d.st   = seed_eff;
        end else if (en) begin
            core_d.st = state_nxt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q.poly <= '0;
            core_q.ord  <= OW'(1);
            core_q.mask <= W'(1);
            core_q.st   <= W'(1);
        end else begin
            core_q <= core_d;
        end
    end

    assign mask_o   = core_q.mask;
    assign code_bit = |(core_q.st & (core_q.mask ^ (core_q.mask >> 1)));

    // R4: stages above the order stay cleared
    a_r4_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (core_q.st & ~core_q.mask) == '0);

    // R3: idle cycles keep the state
    a_r3_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load) |=> $stable(core_q.st));

    // R1: a load never leaves an all-zero start state
    a_r1_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (core_q.st != '0));
endmodule

// File: rtl/pn_period_monitor.sv
module pn_period_monitor
    import pn_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         step,
    input  logic [W-1:0] seed_eff,
    input  logic [W-1:0] state_nxt,
    input  logic [W-1:0] mask,
    output logic [W:0]   period,
    output logic         period_valid,
    output logic         maximal,
    output logic         overrun
);
    localparam logic [W:0] LIMIT = (W+1)'(1) << W;

    typedef struct packed {
        mon_phase_e   phase;
        logic [W:0]   cnt;
        logic [W:0]   per;
        logic         vld;
        logic         mx;
        logic [W-1:0] start;
    } mon_t;

    mon_t mon_d, mon_q;
    logic [W:0] cnt_inc;

    always_comb begin
        mon_d     = mon_q;
        mon_d.vld = 1'b0;
        cnt_inc   = mon_q.cnt + (W+1)'(1);
        if (load) begin
            mon_d.phase = MON_RUN;
            mon_d.cnt   = '0;
            mon_d.per   = '0;
            mon_d.mx    = 1'b0;
            mon_d.start = seed_eff;
        end else if (step && mon_q.phase == MON_RUN) begin
            mon_d.cnt = cnt_inc;
            if (state_nxt == mon_q.start) begin
                mon_d.phase = MON_DONE;
                mon_d.per   = cnt_inc;
                mon_d.vld   = 1'b1;
                mon_d.mx    = (cnt_inc == {1'b0, mask});
            end else if (cnt_inc == LIMIT) begin
                mon_d.phase = MON_OVER;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mon_q.phase <= MON_IDLE;
            mon_q.cnt   <= '0;
            mon_q.per   <= '0;
            mon_q.vld   <= 1'b0;
            mon_q.mx    <= 1'b0;
            mon_q.start <= W'(1);
        end else begin
            mon_q <= mon_d;
        end
    end

    assign period       = mon_q.per;
    assign period_valid = mon_q.vld;
    assign maximal      = mon_q.mx;
    assign overrun      = (mon_q.phase == MON_OVER);

    // R6: the report is a single-cycle pulse
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |=> !period_valid);

    // R6: a reported period is never zero
    a_r6_period_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        period_valid |-> (period != '0));

    // R9: overrun and a period report exclude each other
    a_r9_overrun_excl: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> (!period_valid && period == '0));

    // R7: maximal only rises together with a report
    a_r7_max_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(maximal) |-> period_valid);
endmodule

// File: rtl/pn_sequencer.sv
module pn_sequencer
    import pn_pkg::*;
#(
    parameter int W = PN_W_DEFAULT
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   en,
    input  logic                   load,
    input  logic [W:0]             poly,
    input  logic [$clog2(W+1)-1:0] order,
    input  logic [W-1:0]           seed,
    output logic                   code_bit,
    output logic [W:0]             period,
    output logic                   period_valid,
    output logic                   maximal,
    output logic                   overrun
);
    localparam int OW = $clog2(W + 1);

    logic [W-1:0] seed_eff;
    logic [W-1:0] state_nxt;
    logic [W-1:0] mask;
    logic         step;

    pn_shift_core #(.W(W), .OW(OW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .load      (load),
        .poly_in   (poly),
        .order_in  (order),
        .seed_in   (seed),
        .seed_eff  (seed_eff),
        .state_nxt (state_nxt),
        .mask_o    (mask),
        .step      (step),
        .code_bit  (code_bit)
    );

    pn_period_monitor #(.W(W)) u_mon (
        .clk          (clk),
        .rst_n        (rst_n),
        .load         (load),
        .step         (step),
        .seed_eff     (seed_eff),
        .state_nxt    (state_nxt),
        .mask         (mask),
        .period       (period),
        .period_valid (period_valid),
        .maximal      (maximal),
        .overrun      (overrun)
    );

    // R11: a load clears the monitor flags on the next cycle
    a_r11_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (!overrun && !maximal && period == '0));
endmodule

// File: tb/pn_sequencer_bench.sv
module pn_sequencer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b0;
    logic        load = 1'b0;
    logic [16:0] poly = '0;
    logic [4:0]  order = '0;
    logic [15:0] seed = '0;
    logic        code_bit;
    logic [16:0] period;
    logic        period_valid;
    logic        maximal;
    logic        overrun;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    pn_sequencer u_pn_sequencer (
        .clk(clk), .rst_n(rst_n), .en(en), .load(load),
        .poly(poly), .order(order), .seed(seed),
        .code_bit(code_bit), .period(period), .period_valid(period_valid),
        .maximal(maximal), .overrun(overrun)
    );

    typedef struct packed {
        logic [16:0] p;
        logic [4:0]  o;
        logic [15:0] s;
        logic [16:0] per;
        logic        mx;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{17'h00003, 5'd1,  16'h0001, 17'd1,     1'b1},  // R7
        '{17'h00007, 5'd2,  16'h0002, 17'd3,     1'b1},  // R7
        '{17'h0000B, 5'd3,  16'h0005, 17'd7,     1'b1},  // R7
        '{17'h00013, 5'd4,  16'h0001, 17'd15,    1'b1},  // R7
        '{17'h0001F, 5'd4,  16'h0003, 17'd5,     1'b0},  // R8
        '{17'h00049, 5'd6,  16'h0001, 17'd9,     1'b0},  // R8
        '{17'h00057, 5'd6,  16'h0007, 17'd21,    1'b0},  // R8
        '{17'h0011B, 5'd8,  16'h0001, 17'd51,    1'b0},  // R8
        '{17'h0011D, 5'd8,  16'h0009, 17'd255,   1'b1},  // R7
        '{17'h00083, 5'd7,  16'h0001, 17'd127,   1'b1},  // R7
        '{17'h00003, 5'd0,  16'h0001, 17'd1,     1'b1},  // R5 order 0 -> 1
        '{17'h0000B, 5'd3,  16'hFFF8, 17'd7,     1'b1}   // R4 masked seed -> 1
    };

    localparam logic [14:0] R2_BITS = 15'b011110101100100;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_load(input logic [16:0] p, input logic [4:0] o,
                           input logic [15:0] s, input logic with_en);
        @(negedge clk);
        poly = p; order = o; seed = s; load = 1'b1; en = with_en;
        @(negedge clk);
        load = 1'b0; en = 1'b0;
    endtask

    task automatic run_period(input int limit, output int found_at);
        found_at = -1;
        en = 1'b1;
        for (int k = 1; k <= limit; k++) begin
            @(negedge clk);
            if (period_valid && found_at < 0) found_at = k;
            if (found_at >= 0) break;
        end
        en = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int at;
        logic [16:0] held;
        bit seen;

        repeat (3) @(negedge clk);
        // R10 reset state
        check(code_bit == 1'b1, "R10 code_bit", int'(code_bit), 1);
        check(period == 0, "R10 period", int'(period), 0);
        check(!period_valid && !maximal && !overrun, "R10 flags",
              int'({period_valid, maximal, overrun}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table walk: R6, R7, R8 and R4/R5 entries
        for (int v = 0; v < NV; v++) begin
            do_load(VEC[v].p, VEC[v].o, VEC[v].s, 1'b0);
            run_period(int'(VEC[v].per) + 4, at);
            check(at == int'(VEC[v].per), "R6 steps to return", at, int'(VEC[v].per));
            check(period == VEC[v].per, "R8 period value", int'(period), int'(VEC[v].per));
            check(maximal == VEC[v].mx, "R7 maximal", int'(maximal), int'(VEC[v].mx));
            held = period;
            en = 1'b1;
            @(negedge clk);
            en = 1'b0;
            check(!period_valid, "R6 single pulse", int'(period_valid), 0);
            check(period == held && maximal == VEC[v].mx, "R7 held after report",
                  int'(period), int'(held));
        end

        // R1 and R2: code bit pattern, with idle cycles between steps (R3)
        do_load(17'h00013, 5'd4, 16'h0001, 1'b0);
        check(code_bit == 1'b0, "R1 top stage after load", int'(code_bit), 0);
        seen = 0;
        for (int k = 1; k <= 15; k++) begin
            en = 1'b1;
            @(negedge clk);
            en = 1'b0;
            if (period_valid) seen = 1;
            check(code_bit == R2_BITS[k-1], "R2 code bit", int'(code_bit), int'(R2_BITS[k-1]));
            if (k == 5) begin
                held = period;
                repeat (3) @(negedge clk);
                check(code_bit == R2_BITS[k-1] && !period_valid, "R3 idle hold",
                      int'(code_bit), int'(R2_BITS[k-1]));
            end
        end
        check(seen && period == 17'd15, "R3 period unaffected by idle", int'(period), 15);

        // R4 zero seed becomes 1
        do_load(17'h00013, 5'd4, 16'h0000, 1'b0);
        run_period(20, at);
        check(at == 15 && period == 17'd15, "R4 zero seed", at, 15);

        // R5 order above 16 clamps to 16
        do_load(17'h16801, 5'd20, 16'h0001, 1'b0);
        en = 1'b1;
        repeat (14) @(negedge clk);
        check(code_bit == 1'b0, "R5 clamp step 14", int'(code_bit), 0);
        @(negedge clk);
        check(code_bit == 1'b1, "R5 clamp step 15", int'(code_bit), 1);
        en = 1'b0;

        // R11 load wins over en, monitor restarts
        do_load(17'h00013, 5'd4, 16'h0008, 1'b1);
        check(code_bit == 1'b1, "R11 load priority", int'(code_bit), 1);
        check(period == 0 && !maximal, "R11 monitor cleared", int'(period), 0);
        run_period(20, at);
        check(at == 15 && maximal, "R11 fresh period", at, 15);

        // full-length order 16
        do_load(17'h16801, 5'd16, 16'hACE1, 1'b0);
        run_period(65540, at);
        check(at == 65535 && period == 17'd65535, "R6 order 16 period", at, 65535);
        check(maximal == 1'b1, "R7 order 16 maximal", int'(maximal), 1);

        // R9 overrun: no constant term, state never returns
        do_load(17'h10000, 5'd16, 16'h0001, 1'b0);
        seen = 0;
        en = 1'b1;
        for (int k = 1; k <= 65535; k++) begin
            @(negedge clk);
            if (period_valid) seen = 1;
        end
        check(!overrun, "R9 no overrun at 65535", int'(overrun), 0);
        @(negedge clk);
        en = 1'b0;
        if (period_valid) seen = 1;
        check(overrun, "R9 overrun at 65536", int'(overrun), 1);
        check(!seen && period == 0, "R9 no report", int'(period), 0);

        // R11 load clears overrun
        do_load(17'h00007, 5'd2, 16'h0001, 1'b0);
        check(!overrun, "R11 overrun cleared", int'(overrun), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule